// File: doc/BRIEF.md
# Maskable Interrupt Enable Flag Controller

This block keeps the enable bit that decides whether a processor core accepts maskable interrupts. It also decides, at every instruction boundary, whether an interrupt is taken. The decode stage drives one-cycle event inputs together with a `retire` strobe. The events are: enable, disable, flags restore from the stack, interrupt-gate entry, and handler return. The strobe marks the cycle in which the instruction that owns those events completes. The core supplies two privilege numbers and a real-mode configuration bit. The controller applies the privilege rules to the flag-changing events and reports a protection fault where the rules require one.

A boundary exists only in a cycle where `retire` is high. In that cycle the block computes the flag value that the retiring instruction leaves behind. It then registers three results: whether an interrupt is taken, which kind it is, and whether the instruction faulted. All three appear on the outputs for one cycle after the retire edge. Taking an interrupt drops the flag on that same edge, which models the automatic disable on handler entry. An enable instruction opens a shadow that covers only the boundary directly after it. Maskable requests therefore wait one further instruction before they can be taken.

Top module: `maskflag_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `int_flag`, `take`, `take_nmi` and `gp_fault` are all 0.
- R2: A permitted `op_set` drives `int_flag` to 1 in the cycle after it retires. A maskable request is not taken at the boundary of that instruction, even if the flag was already 1. It is taken at the next retire.
- R3: A permitted `op_clr` drives `int_flag` to 0, and no maskable request is taken at its own boundary or at any later one until the flag is set again.
- R4: With `real_mode` low and `cpl` numerically greater than `iopl`, an `op_set` or `op_clr` raises `gp_fault` for one cycle and leaves `int_flag` unchanged. Equal values are permitted.
- R5: `op_pop` loads `int_flag` from bit 9 of `flags_word` when `cpl` is at most `iopl`. Otherwise the flag is unchanged and `gp_fault` stays 0. A pop does not open a shadow, so a request can be taken at its own boundary.
- R6: With `real_mode` high the privilege numbers are ignored: set, clear and pop always act on the flag and never fault.
- R7: `op_gate` clears the flag, and no maskable request is taken at its boundary. `op_iret` loads the flag from bit 9 of `flags_word` without any privilege check.
- R8: `take` is 1 for one cycle, with `take_nmi` = 0, when a retire sees `irq` high and the flag left by that instruction is 1 and outside the shadow.
- R9: A retire that sees `nmi` high produces `take` = 1 and `take_nmi` = 1 whatever the flag value. This takes priority over a simultaneous `irq`.
- R10: On the edge where `take` rises, `int_flag` becomes 0.
- R11: In a cycle with `retire` low, all events, `irq` and `nmi` are ignored: `take` and `gp_fault` stay 0 next cycle and `int_flag` holds.
- R12: If several events come together, only one acts, in the order gate, return, pop, clear, set. A fault is raised only when clear or set is the event that acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| real_mode | input | 1 | 1 = no privilege checks |
| cpl | input | PL_W | Current privilege number |
| iopl | input | PL_W | I/O privilege number |
| retire | input | 1 | An instruction completes this cycle |
| op_set | input | 1 | Enable-flag instruction |
| op_clr | input | 1 | Disable-flag instruction |
| op_pop | input | 1 | Flags restore from stack |
| op_gate | input | 1 | Interrupt-gate entry |
| op_iret | input | 1 | Handler return |
| flags_word | input | FLAGS_W | Flags word for pop and return; bit 9 is the enable |
| irq | input | 1 | Maskable request level |
| nmi | input | 1 | Non-maskable request level |
| int_flag | output | 1 | Current enable flag |
| take | output | 1 | Interrupt accepted (one cycle) |
| take_nmi | output | 1 | 1 = accepted one was non-maskable |
| gp_fault | output | 1 | Protection fault (one cycle) |

## Verification
Two results can arise at the same boundary: a privilege fault on a set or clear, and an interrupt take. The bench retires an under-privileged enable while `nmi` is high. It expects `gp_fault`, `take` and `take_nmi` all high in the following cycle, with the flag still 0. A second overlap is the shadow meeting a pending request. An enable retired with `irq` high must give flag 1 and no take, and the very next retire must give the take with the flag back at 0.

// File: rtl/maskflag_ctl.sv
module maskflag_ctl #(
  parameter int FLAGS_W = 32,
  parameter int IF_POS  = 9,
  parameter int PL_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               real_mode,
  input  logic [PL_W-1:0]    cpl,
  input  logic [PL_W-1:0]    iopl,
  input  logic               retire,
  input  logic               op_set,
  input  logic               op_clr,
  input  logic               op_pop,
  input  logic               op_gate,
  input  logic               op_iret,
  input  logic [FLAGS_W-1:0] flags_word,
  input  logic               irq,
  input  logic               nmi,
  output logic               int_flag,
  output logic               take,
  output logic               take_nmi,
  output logic               gp_fault
);

  logic flag_q, take_q, kind_q, fault_q;
  logic priv_ok, flag_nx, shadow, fault_nx, take_nx;

  assign priv_ok = real_mode || (cpl <= iopl);

  always_comb begin
    flag_nx  = flag_q;
    shadow   = 1'b0;
    fault_nx = 1'b0;
    if (op_gate)
      flag_nx = 1'b0;
    else if (op_iret)
      flag_nx = flags_word[IF_POS];
    else if (op_pop) begin
      if (priv_ok) flag_nx = flags_word[IF_POS];
    end else if (op_clr) begin
      if (priv_ok) flag_nx = 1'b0;
      else         fault_nx = 1'b1;
    end else if (op_set) begin
      if (priv_ok) begin
        flag_nx = 1'b1;
        shadow  = 1'b1;
      end else
        fault_nx = 1'b1;
    end
  end

  assign take_nx = nmi || (irq && flag_nx && !shadow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      take_q  <= 1'b0;
      kind_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      take_q  <= retire && take_nx;
      kind_q  <= retire && nmi;
      fault_q <= retire && fault_nx;
      if (retire) flag_q <= take_nx ? 1'b0 : flag_nx;
    end
  end

  assign int_flag = flag_q;
  assign take     = take_q;
  assign take_nmi = kind_q;
  assign gp_fault = fault_q;

endmodule

// File: rtl/maskflag_ctl_chk.sv
module maskflag_ctl_chk #(
  parameter int PL_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            real_mode,
  input logic [PL_W-1:0] cpl,
  input logic [PL_W-1:0] iopl,
  input logic            retire,
  input logic            op_set,
  input logic            op_clr,
  input logic            op_pop,
  input logic            op_gate,
  input logic            op_iret,
  input logic            irq,
  input logic            nmi,
  input logic            int_flag,
  input logic            take,
  input logic            take_nmi,
  input logic            gp_fault
);

  logic low_priv, lone_set, lone_clr, lone_pop;
  assign low_priv = !real_mode && (cpl > iopl);
  assign lone_set = op_set && !op_clr && !op_pop && !op_gate && !op_iret;
  assign lone_clr = op_clr && !op_pop && !op_gate && !op_iret;
  assign lone_pop = op_pop && !op_gate && !op_iret;

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> (!take && !gp_fault && int_flag == $past(int_flag)));

  p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !int_flag);

  p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && nmi) |=> (take && take_nmi));

  p_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> take);

  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && low_priv && (lone_set || lone_clr)) |=>
      (gp_fault && (take || int_flag == $past(int_flag))));

  p_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && lone_set && !low_priv && !nmi) |=> (int_flag && !take));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && lone_clr && !low_priv && !nmi) |=> (!int_flag && !take));

  p_pop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && lone_pop && low_priv) |=>
      (!gp_fault && (take || int_flag == $past(int_flag))));

endmodule

bind maskflag_ctl maskflag_ctl_chk #(.PL_W(PL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .cpl(cpl), .iopl(iopl),
  .retire(retire), .op_set(op_set), .op_clr(op_clr), .op_pop(op_pop),
  .op_gate(op_gate), .op_iret(op_iret), .irq(irq), .nmi(nmi),
  .int_flag(int_flag), .take(take), .take_nmi(take_nmi), .gp_fault(gp_fault)
);

// File: tb/sim_maskflag_ctl.sv
module sim_maskflag_ctl;
  localparam int PERIOD = 10;
  localparam int NV = 30;

  // fields: req[21:18] rm[17] cpl[16:15] iopl[14:13] set clr pop gate iret[12:8]
  //         fb irq nmi ret[7:4] exp flag take nmi fault[3:0]
  localparam logic [21:0] TBL [NV] = '{
    22'b1011_0_00_00_10000_0110_0000, // R11 no retire
    22'b1000_0_00_00_00000_0101_0000, // R8 flag 0
    22'b0010_0_00_00_10000_0101_1000, // R2 shadow
    22'b1000_0_00_00_00000_0101_0100, // R8 R10 take
    22'b0010_0_00_00_10000_0001_1000, // R2 set
    22'b0011_0_00_00_01000_0101_0000, // R3 clear with irq
    22'b0011_0_00_00_00000_0101_0000, // R3 stays masked
    22'b1001_0_00_00_00000_0011_0110, // R9 nmi, flag 0
    22'b0010_0_00_00_10000_0001_1000, // R2 set
    22'b1001_0_00_00_00000_0111_0110, // R9 nmi beats irq
    22'b0100_0_11_00_10000_0001_0001, // R4 set fault
    22'b0100_0_01_10_10000_0001_1000, // R4 cpl below iopl
    22'b0100_0_11_10_01000_0001_1001, // R4 clear fault
    22'b0100_0_10_10_01000_0001_0000, // R4 equal permitted
    22'b0101_0_11_00_00100_1001_0000, // R5 pop ignored
    22'b0101_0_00_00_00100_1101_0100, // R5 pop, no shadow
    22'b0101_0_00_00_00100_1001_1000, // R5 pop sets
    22'b0101_0_11_01_00100_0001_1000, // R5 pop 0 ignored
    22'b0110_1_11_00_01000_0001_0000, // R6 clear
    22'b0110_1_11_00_00100_1001_1000, // R6 pop
    22'b0111_0_00_00_00010_0101_0000, // R7 gate
    22'b0111_0_00_00_00001_1001_1000, // R7 iret 1
    22'b0111_0_00_00_00001_0001_0000, // R7 iret 0
    22'b1100_0_11_00_10010_0001_0000, // R12 gate over set
    22'b1100_0_00_00_01100_1001_1000, // R12 pop over clr
    22'b1011_0_00_00_01000_0010_1000, // R11 ignored
    22'b0010_0_00_00_10000_0101_1000, // R2 set when already 1
    22'b0010_0_00_00_00000_0101_0100, // R2 taken next
    22'b1010_0_00_00_00000_0001_0000, // R10 flag stays 0
    22'b0100_0_11_00_10000_0011_0111  // R4 R9 fault with nmi
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic real_mode = 1'b0;
  logic [1:0] cpl = '0, iopl = '0;
  logic retire = 1'b0, op_set = 1'b0, op_clr = 1'b0, op_pop = 1'b0;
  logic op_gate = 1'b0, op_iret = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic [31:0] flags_word = '0;
  logic int_flag, take, take_nmi, gp_fault;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  maskflag_ctl u0 (
    .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .cpl(cpl), .iopl(iopl),
    .retire(retire), .op_set(op_set), .op_clr(op_clr), .op_pop(op_pop),
    .op_gate(op_gate), .op_iret(op_iret), .flags_word(flags_word),
    .irq(irq), .nmi(nmi), .int_flag(int_flag), .take(take),
    .take_nmi(take_nmi), .gp_fault(gp_fault)
  );

  task automatic check(input int req, input logic [3:0] exp);
    logic [3:0] got;
    got = {int_flag, take, take_nmi, gp_fault};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d flag/take/nmi/fault got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [21:0] v);
    real_mode = v[17]; cpl = v[16:15]; iopl = v[14:13];
    op_set = v[12]; op_clr = v[11]; op_pop = v[10]; op_gate = v[9]; op_iret = v[8];
    flags_word = (32'h5A5A_5DA5 & ~32'h0000_0200) | (32'(v[7]) << 9);
    irq = v[6]; nmi = v[5]; retire = v[4];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 4'b0000);                 // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 4'b0000);                 // R1 first cycle after release
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(negedge clk);
      check(int'(TBL[i][21:18]), TBL[i][3:0]);
    end
    apply(22'b0010_0_00_00_10000_0001_1000);
    @(negedge clk);
    check(2, 4'b1000);
    apply('0);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 4'b0000);                 // R1 reset clears a set flag
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 4'b0000);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule